// File: doc/BRIEF.md
# I2C Bus Condition Controller

This block is the condition-control slice of an I2C master. Software writes a small control register to request a start, a repeated start or a stop condition. A sequencer then drives the open-drain SCL and SDA pull-down outputs through the required line pattern. The pulse widths are set by hold and setup cycle counts.

The bus-busy flag does not follow the commands. It tracks what actually appears on the wires. Both line inputs pass through synchronizers, and the flag then follows start and stop conditions seen on the bus, whether this master or another one made them.

The block also filters the acknowledge bit that the byte engine reports. With acknowledge checking off, received acknowledge values are dropped and the transfer runs on. With it on, a received 1 latches a status bit and raises a suspend output.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: The busy flag (read bit 2) sets when the synchronized SDA falls while the synchronized SCL is high, whoever drives the lines.
- R2: The busy flag clears when the synchronized SDA rises while the synchronized SCL is high.
- R3: A write with bit 0 = 0 and bit 2 = 1, while the mode inputs allow it, issues a start. SDA is pulled low with SCL released for HOLD_CYC cycles, and then SCL is pulled low. If the bus is already owned, SDA is first released while SCL stays low, then both lines are released for SETUP_CYC cycles before the start.
- R4: A write with bit 0 = 0 and bit 2 = 0, while the bus is owned, issues a stop. SCL is released with SDA held low for SETUP_CYC cycles, and then SDA is released.
- R5: A start request is ignored unless both the master-mode and transmit-mode inputs are 1.
- R6: Read bit 0 always returns 1. A write with bit 0 = 1 issues no condition.
- R7: While the acknowledge enable (write/read bit 3) is 0, received acknowledge values are ignored. The acknowledge status (read bit 1) stays 0 and the suspend output stays 0.
- R8: While the acknowledge enable is 1, each received acknowledge value is loaded into the acknowledge status. A received 1 asserts the suspend output.
- R9: A command written while a sequence is running is held. It runs once that sequence finishes.
- R10: After reset both lines are released, and the read value is 4'b0001. This means busy 0, acknowledge status 0 and acknowledge enable 0.
- R11: A stop request while the bus is not owned by this block leaves the lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 4 | Write data: [0] command inhibit, [2] busy request, [3] acknowledge enable |
| reg_rdata | output | 4 | Read data: [0] constant 1, [1] acknowledge status, [2] busy, [3] acknowledge enable |
| mst_mode | input | 1 | Master mode selected |
| tx_mode | input | 1 | Transmit mode selected |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_pull_low | output | 1 | Drive SCL low when 1 |
| sda_pull_low | output | 1 | Drive SDA low when 1 |
| ack_valid | input | 1 | Received acknowledge strobe |
| ack_value | input | 1 | Received acknowledge bit |
| xfer_suspend | output | 1 | Transfer suspended on a refused acknowledge |

## Verification
The assertions check on every cycle that:
- each busy-flag edge follows a detected line condition;
- each start holds SDA low for exactly HOLD_CYC cycles before SCL falls;
- each stop keeps SCL released for exactly SETUP_CYC cycles before SDA lets go;
- a disabled acknowledge enable never shows status or suspend.

Only the bench scenarios can show the following:
- commands are gated by the mode inputs and the inhibit bit;
- a held command runs after the sequence in progress;
- a stop on an unowned bus is dropped;
- the busy flag reacts to another master on the wires.

// File: rtl/i2c_cond_pkg.sv
// Shared definitions for the I2C condition controller.
// Assumes a 4-bit control register; the bit positions below are the
// software contract and are decoded by the top module.
package i2c_cond_pkg;

    localparam int REG_W       = 4;
    localparam int BIT_INHIBIT = 0;
    localparam int BIT_ACKSTAT = 1;
    localparam int BIT_BUSY    = 2;
    localparam int BIT_ACKEN   = 3;

    // Condition sequencer states.
    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_HOLD     = 3'd1,
        SQ_OWN      = 3'd2,
        SQ_SP_SETUP = 3'd3,
        SQ_RS_REL   = 3'd4,
        SQ_RS_SETUP = 3'd5
    } seq_state_t;

    // One queued command.
    typedef struct packed {
        logic valid;
        logic start;
    } cmd_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Line watcher: synchronizes SCL and SDA through SYNC_STAGES flops, then
// detects start/stop conditions and keeps the bus-busy flag.
// Assumes asynchronous line inputs that idle high (released).
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_busy
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;
    logic                   sda_s;

    // First synchronizer stage samples the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
        end
    end

    // Remaining synchronizer stages.
    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[LAST];
    assign sda_s = sda_pipe[LAST];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Conditions: SDA edge while SCL stays high.
    always_comb begin
        start_seen = scl_s && scl_prev && sda_prev && !sda_s;
        stop_seen  = scl_s && scl_prev && !sda_prev && sda_s;
    end

    // Busy flag follows conditions seen on the wires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
        end else if (start_seen) begin
            bus_busy <= 1'b1;
        end else if (stop_seen) begin
            bus_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_cond_seq.sv
// Condition sequencer: turns start/stop commands into SCL/SDA pull-down
// patterns with HOLD_CYC and SETUP_CYC timing. It keeps one pending slot.
// Assumes commands arrive as single-cycle strobes, already gated by mode.
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int HOLD_CYC  = 4,
    parameter int SETUP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_start,
    output logic scl_low,
    output logic sda_low
);

    localparam int MAXC = (HOLD_CYC > SETUP_CYC) ? HOLD_CYC : SETUP_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);

    seq_state_t    state;
    seq_state_t    state_nx;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    cmd_t          pend;
    logic          ready;
    logic          take_pend;
    logic          take_new;
    logic          act_valid;
    logic          act_start;

    // Command selection: a held command goes before a new one.
    always_comb begin
        ready     = (state == SQ_IDLE) || (state == SQ_OWN);
        take_pend = ready && pend.valid;
        take_new  = ready && !pend.valid && req_valid;
        act_valid = take_pend || take_new;
        act_start = take_pend ? pend.start : req_start;
    end

    // Pending slot: hold a command that cannot be taken this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (req_valid && !take_new) begin
            pend.valid <= 1'b1;
            pend.start <= req_start;
        end else if (take_pend) begin
            pend.valid <= 1'b0;
        end
    end

    // Next-state and counter logic.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SQ_IDLE: begin
                if (act_valid && act_start) begin
                    state_nx = SQ_HOLD;
                    cnt_nx   = '0;
                end
            end
            SQ_OWN: begin
                if (act_valid) begin
                    state_nx = act_start ? SQ_RS_REL : SQ_SP_SETUP;
                    cnt_nx   = '0;
                end
            end
            SQ_HOLD: begin
                if (cnt == HOLD_LAST) begin
                    state_nx = SQ_OWN;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            SQ_SP_SETUP: begin
                if (cnt == SETUP_LAST) begin
                    state_nx = SQ_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            SQ_RS_REL: begin
                state_nx = SQ_RS_SETUP;
                cnt_nx   = '0;
            end
            SQ_RS_SETUP: begin
                if (cnt == SETUP_LAST) begin
                    state_nx = SQ_HOLD;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = SQ_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Line pull-downs decoded from the state.
    always_comb begin
        scl_low = (state == SQ_OWN) || (state == SQ_RS_REL);
        sda_low = (state == SQ_HOLD) || (state == SQ_OWN) || (state == SQ_SP_SETUP);
    end

endmodule

// File: rtl/i2c_ack_ctrl.sv
// Acknowledge filter: keeps the acknowledge enable and status bits and
// raises suspend when an enabled acknowledge comes back as 1.
// Assumes ack_valid is a single-cycle strobe from the byte engine.
module i2c_ack_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_ack_en,
    input  logic ack_valid,
    input  logic ack_value,
    output logic ack_en,
    output logic ack_stat,
    output logic suspend
);

    // Acknowledge enable register, written on every register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en <= 1'b0;
        end else if (cfg_we) begin
            ack_en <= cfg_ack_en;
        end
    end

    // Acknowledge status: loaded only while enabled, cleared on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_stat <= 1'b0;
        end else if (cfg_we && !cfg_ack_en) begin
            ack_stat <= 1'b0;
        end else if (ack_valid && ack_en) begin
            ack_stat <= ack_value;
        end
    end

    // Suspend while an enabled refusal is latched.
    always_comb begin
        suspend = ack_en && ack_stat;
    end

endmodule

// File: rtl/i2c_cond_ctrl.sv
// Top of the I2C condition controller. It decodes register writes into
// commands, gates starts on the mode inputs, and assembles the read view.
// Assumes open-drain lines: the outputs request a low, and the level is
// read back on scl_in/sda_in.
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int HOLD_CYC    = 4,
    parameter int SETUP_CYC   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             mst_mode,
    input  logic             tx_mode,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull_low,
    output logic             sda_pull_low,
    input  logic             ack_valid,
    input  logic             ack_value,
    output logic             xfer_suspend
);

    logic line_start;
    logic line_stop;
    logic bus_busy;
    logic cmd_valid;
    logic cmd_start;
    logic ack_en;
    logic ack_stat;

    // Command decode: inhibit blocks all; a start needs master transmit mode.
    always_comb begin
        cmd_start = reg_wdata[BIT_BUSY];
        cmd_valid = reg_we && !reg_wdata[BIT_INHIBIT] &&
                    (!cmd_start || (mst_mode && tx_mode));
    end

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_seen(line_start),
        .stop_seen (line_stop),
        .bus_busy  (bus_busy)
    );

    i2c_cond_seq #(
        .HOLD_CYC (HOLD_CYC),
        .SETUP_CYC(SETUP_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(cmd_valid),
        .req_start(cmd_start),
        .scl_low  (scl_pull_low),
        .sda_low  (sda_pull_low)
    );

    i2c_ack_ctrl u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (reg_we),
        .cfg_ack_en(reg_wdata[BIT_ACKEN]),
        .ack_valid (ack_valid),
        .ack_value (ack_value),
        .ack_en    (ack_en),
        .ack_stat  (ack_stat),
        .suspend   (xfer_suspend)
    );

    // Read view; the inhibit bit is never stored and reads as 1.
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[BIT_INHIBIT] = 1'b1;
        reg_rdata[BIT_ACKSTAT] = ack_stat;
        reg_rdata[BIT_BUSY]    = bus_busy;
        reg_rdata[BIT_ACKEN]   = ack_en;
    end

endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
// Protocol checker for i2c_cond_ctrl, attached by bind. It measures how long
// SDA is held low with SCL released and compares that with the timing
// parameters.
module i2c_cond_ctrl_chk #(
    parameter int HOLD_CYC  = 4,
    parameter int SETUP_CYC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [3:0] reg_rdata,
    input logic       scl_pull_low,
    input logic       sda_pull_low,
    input logic       ack_valid,
    input logic       ack_value,
    input logic       xfer_suspend,
    input logic       line_start,
    input logic       line_stop
);

    logic [15:0] run_cnt;

    // Length of the current SDA-low, SCL-released stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (sda_pull_low && !scl_pull_low) begin
            if (run_cnt != 16'hFFFF) run_cnt <= run_cnt + 16'd1;
        end else begin
            run_cnt <= '0;
        end
    end

    assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[2]) |-> $past(line_start));

    assert_busy_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[2]) |-> $past(line_stop));

    assert_start_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_pull_low) && sda_pull_low) |-> (run_cnt == 16'(HOLD_CYC)));

    assert_stop_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull_low) && !scl_pull_low) |-> (run_cnt == 16'(SETUP_CYC)));

    assert_ack_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[3] |-> (!reg_rdata[1] && !xfer_suspend));

    assert_ack_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_value && reg_rdata[3] && !reg_we) |=> xfer_suspend);

endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk #(
    .HOLD_CYC (HOLD_CYC),
    .SETUP_CYC(SETUP_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low),
    .ack_valid   (ack_valid),
    .ack_value   (ack_value),
    .xfer_suspend(xfer_suspend),
    .line_start  (line_start),
    .line_stop   (line_stop)
);

// File: tb/i2c_cond_ctrl_tb.sv
// Self-checking bench for i2c_cond_ctrl: directed corner cases followed by
// seeded random command and acknowledge traffic against a bench model.
module i2c_cond_ctrl_tb;

    localparam int HOLD  = 4;
    localparam int SETUP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_wdata = 4'b0001;
    logic [3:0] reg_rdata;
    logic       mst_mode = 1'b1;
    logic       tx_mode = 1'b1;
    logic       scl_pull_low;
    logic       sda_pull_low;
    logic       ext_scl_low = 1'b0;
    logic       ext_sda_low = 1'b0;
    logic       ack_valid = 1'b0;
    logic       ack_value = 1'b0;
    logic       xfer_suspend;
    logic       scl_line;
    logic       sda_line;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state.
    logic m_owned  = 1'b0;
    logic m_ack_en = 1'b0;
    logic m_stat   = 1'b0;

    always #2 clk = ~clk;

    // Wired-AND open-drain bus.
    assign scl_line = !(scl_pull_low || ext_scl_low);
    assign sda_line = !(sda_pull_low || ext_sda_low);

    i2c_cond_ctrl #(
        .HOLD_CYC (HOLD),
        .SETUP_CYC(SETUP)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .mst_mode    (mst_mode),
        .tx_mode     (tx_mode),
        .scl_in      (scl_line),
        .sda_in      (sda_line),
        .scl_pull_low(scl_pull_low),
        .sda_pull_low(sda_pull_low),
        .ack_valid   (ack_valid),
        .ack_value   (ack_value),
        .xfer_suspend(xfer_suspend)
    );

    // Expected read value: {ack enable, busy, ack status, constant 1}.
    function automatic logic [3:0] exp_rd(logic en, logic busy, logic stat);
        return {en, busy, stat, 1'b1};
    endfunction

    // Expected suspend output.
    function automatic logic exp_susp(logic en, logic stat);
        return en && stat;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Register write; returns at the negedge after the write edge.
    task automatic wr(logic inh, logic busy, logic en);
        reg_wdata = {en, busy, 1'b0, inh};
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        m_ack_en  = en;
        if (!en) m_stat = 1'b0;
        if (!inh && busy && mst_mode && tx_mode) m_owned = 1'b1;
        else if (!inh && !busy && m_owned)      m_owned = 1'b0;
    endtask

    task automatic ack_pulse(logic v);
        ack_value = v;
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        if (m_ack_en) m_stat = v;
    endtask

    // Watch n cycles and return whether any line was pulled.
    task automatic watch_quiet(int n, output logic pulled);
        pulled = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (scl_pull_low || sda_pull_low) pulled = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int cnt;
        logic pulled;
        logic saw_own;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R10: reset state.
        chk("R10 rdata", reg_rdata, 4'b0001);
        chk("R10 lines", {scl_pull_low, sda_pull_low}, 2'b00);
        chk("R10 suspend", xfer_suspend, 1'b0);

        // R3: start from idle.
        wr(1'b0, 1'b1, 1'b0);
        cnt = 0;
        while (sda_pull_low && !scl_pull_low && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R3 hold cycles", cnt, HOLD);
        chk("R3 owned lines", {scl_pull_low, sda_pull_low}, 2'b11);
        tick(8);
        chk("R1 busy after own start", reg_rdata[2], 1'b1);

        // R3: repeated start from owned.
        wr(1'b0, 1'b1, 1'b0);
        chk("R3 repeat releases SDA first", {scl_pull_low, sda_pull_low}, 2'b10);
        tick(30);
        chk("R3 repeat ends owned", {scl_pull_low, sda_pull_low}, 2'b11);
        chk("R3 busy kept across repeat", reg_rdata[2], 1'b1);

        // R4: stop.
        wr(1'b0, 1'b0, 1'b0);
        cnt = 0;
        while (sda_pull_low && !scl_pull_low && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        chk("R4 setup cycles", cnt, SETUP);
        chk("R4 released", {scl_pull_low, sda_pull_low}, 2'b00);
        tick(8);
        chk("R2 busy after own stop", reg_rdata[2], 1'b0);

        // R11: stop while idle.
        wr(1'b0, 1'b0, 1'b0);
        watch_quiet(15, pulled);
        chk("R11 stop ignored when idle", pulled, 1'b0);

        // R5: mode gating.
        mst_mode = 1'b0;
        wr(1'b0, 1'b1, 1'b0);
        watch_quiet(15, pulled);
        chk("R5 no start without master", pulled, 1'b0);
        mst_mode = 1'b1;
        tx_mode  = 1'b0;
        wr(1'b0, 1'b1, 1'b0);
        watch_quiet(15, pulled);
        chk("R5 no start without transmit", pulled, 1'b0);
        tx_mode = 1'b1;

        // R6: inhibit bit.
        wr(1'b1, 1'b1, 1'b0);
        watch_quiet(15, pulled);
        chk("R6 inhibited write issues nothing", pulled, 1'b0);
        chk("R6 inhibit reads one", reg_rdata[0], 1'b1);

        // R9: stop written during the start sequence.
        wr(1'b0, 1'b1, 1'b0);
        wr(1'b0, 1'b0, 1'b0);
        saw_own = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (scl_pull_low) saw_own = 1'b1;
            @(negedge clk);
        end
        chk("R9 start completed", saw_own, 1'b1);
        chk("R9 pending stop executed", {scl_pull_low, sda_pull_low}, 2'b00);
        chk("R9 busy clear", reg_rdata[2], 1'b0);

        // R1/R2: another master on the bus.
        ext_sda_low = 1'b1;
        tick(6);
        chk("R1 busy on foreign start", reg_rdata[2], 1'b1);
        chk("R1 lines untouched", {scl_pull_low, sda_pull_low}, 2'b00);
        ext_sda_low = 1'b0;
        tick(6);
        chk("R2 busy clear on foreign stop", reg_rdata[2], 1'b0);

        // R8 / R7: acknowledge handling.
        wr(1'b1, 1'b0, 1'b1);
        ack_pulse(1'b1);
        chk("R8 status set", reg_rdata[1], 1'b1);
        chk("R8 suspend", xfer_suspend, 1'b1);
        ack_pulse(1'b0);
        chk("R8 status cleared by ack 0", reg_rdata[1], 1'b0);
        wr(1'b1, 1'b0, 1'b0);
        ack_pulse(1'b1);
        chk("R7 status held 0", reg_rdata[1], 1'b0);
        chk("R7 no suspend", xfer_suspend, 1'b0);

        // Random commands against the ownership model (R3, R4, R5, R6, R11).
        for (int it = 0; it < 30; it++) begin
            mst_mode = ($urandom % 4) != 0;
            tx_mode  = ($urandom % 4) != 0;
            wr(($urandom % 3) == 0, $urandom % 2, $urandom % 2);
            tick(40);
            chk("R3/R4 random lines", {scl_pull_low, sda_pull_low}, {m_owned, m_owned});
            chk("R1/R2 random read", reg_rdata, exp_rd(m_ack_en, m_owned, m_stat));
        end

        // Random acknowledge traffic (R7, R8).
        for (int it = 0; it < 80; it++) begin
            if (($urandom % 5) == 0) wr(1'b1, 1'b0, $urandom % 2);
            ack_pulse($urandom % 2);
            chk("R7/R8 random status", reg_rdata, exp_rd(m_ack_en, m_owned, m_stat));
            chk("R7/R8 random suspend", xfer_suspend, exp_susp(m_ack_en, m_stat));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule